// File: doc/BRIEF.md
# Interrupt Entry Context-Save Sequencer

This block performs the processor-side work that follows the acceptance of an interrupt. An arbiter upstream supplies a one-cycle accept strobe along with a class tag, a requested priority level and an optional fixed priority level. The block captures the live flag word, program counter and both stack pointers in that cycle. It then writes the pre-interrupt context to memory as three 16-bit write cycles on a downward-growing stack. When the last write is accepted, it publishes the updated flag word and stack pointers and pulses `done`.

The stack that receives the context depends on the class. Hardware interrupts and software interrupts numbered 0 to 31 always use the interrupt stack and clear the stack-select flag. Software interrupts numbered 32 to 63 use the stack that the captured stack-select flag names, and they leave that flag as it was. In every class the enable and debug flags are cleared and the priority field is rewritten. Sources that carry a fixed priority (reset, non-maskable, debugger, watchdog, single-step, address-match, break, overflow, undefined-instruction) assert `fixed_en`, and `fixed_level` then replaces the requested level.

The sequencer has five states. In IDLE, an accept moves it to PC_HI. PC_HI goes to PC_LO, and PC_LO goes to FLAG, each when its write is acknowledged by `mem_rdy`. FLAG goes to DONE when its write is acknowledged. DONE returns to IDLE after one cycle. Each write state stays where it is while `mem_rdy` is low.

Top module: `irq_ctx_saver`

## Requirements
- R1: After reset, `mem_wr`, `busy` and `done` are 0, and `flg_out`, `isp_out` and `usp_out` are all zero.
- R2: An accepted interrupt produces exactly three write cycles, in this order: PC high word (PC bits above 15, zero-extended), PC low word (PC bits 15:0), flag word. Their addresses are S-2, S-4 and S-6, where S is the selected stack pointer and arithmetic wraps modulo 2^SP_W.
- R3: Class codes are 0 = hardware, 1 = software 0 to 31, 2 = software 32 to 63, and 3 behaves as hardware. Classes 0, 1 and 3 push onto `isp_in`, clear U (flag bit 7) in `flg_out`, and return `usp_out` equal to the captured `usp_in`.
- R4: Class 2 pushes onto `usp_in` when the captured U (bit 7) is 1 and onto `isp_in` when it is 0. U in `flg_out` equals the captured U. The pointer that was not used is returned unchanged.
- R5: The stacked flag word and PC are the values captured in the accept cycle. Later changes on the inputs do not alter them.
- R6: `flg_out` clears I (bit 6) and D (bit 2). Every bit outside U, I, D and the priority field equals the captured flag word.
- R7: The priority field, `flg_out[14:12]`, equals `fixed_level` when `fixed_en` was 1 at acceptance, and `req_level` otherwise.
- R8: While `mem_wr` is 1 and `mem_rdy` is 0, the next cycle keeps `mem_wr` at 1, with `mem_addr` and `mem_wdata` unchanged.
- R9: `done` is 1 for exactly one cycle, the cycle after the flag write is acknowledged. From that cycle on, `flg_out`, `isp_out` and `usp_out` hold the new values, with the selected pointer equal to S-6.
- R10: An accept while `busy` is 1 is ignored. It starts no additional write and does not change the values being saved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accept | input | 1 | One-cycle strobe: interrupt accepted |
| irq_class | input | 2 | Class tag (0 hardware, 1 low software, 2 high software, 3 hardware) |
| req_level | input | 3 | Requested priority level |
| fixed_en | input | 1 | Source uses a fixed priority level |
| fixed_level | input | 3 | Fixed priority level for such sources |
| flg_in | input | 16 | Current flag word |
| pc_in | input | PC_W | Current program counter |
| isp_in | input | SP_W | Current interrupt stack pointer |
| usp_in | input | SP_W | Current user stack pointer |
| mem_rdy | input | 1 | Memory accepts the current write |
| mem_wr | output | 1 | Write request |
| mem_addr | output | SP_W | Write address |
| mem_wdata | output | 16 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| flg_out | output | 16 | Updated flag word |
| isp_out | output | SP_W | Updated interrupt stack pointer |
| usp_out | output | SP_W | Updated user stack pointer |

## Verification
The bench builds the block with PC_W = 20 and SP_W = 16. With those values the PC high word carries four live bits above zero padding, so a truncation or misaligned split shows up as a wrong data word. A 16-bit pointer starting at 0x0002 makes the second push wrap to 0xFFFE. The stimulus table covers all four class codes and both values of the captured U flag. It also inserts stall lengths from zero to three cycles, which reaches every hold path in the write states.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
    localparam int WORD_W  = 16;
    localparam int IPL_W   = 3;
    localparam int U_BIT   = 7;
    localparam int I_BIT   = 6;
    localparam int D_BIT   = 2;
    localparam int IPL_LSB = 12;

    typedef enum logic [1:0] {
        CLS_HW    = 2'd0,
        CLS_SW_LO = 2'd1,
        CLS_SW_HI = 2'd2,
        CLS_RSVD  = 2'd3
    } irq_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PC_HI,
        ST_PC_LO,
        ST_FLAG,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/irq_ctx_stacksel.sv
module irq_ctx_stacksel
    import irq_ctx_pkg::*;
#(
    parameter int SP_W = 16
) (
    input  irq_class_e       cls,
    input  logic             u_flag,
    input  logic [SP_W-1:0]  isp,
    input  logic [SP_W-1:0]  usp,
    output logic             use_usp,
    output logic [SP_W-1:0]  base_sp
);
    // Only high software numbers honour the current stack selection.
    always_comb begin
        use_usp = (cls == CLS_SW_HI) && u_flag;
        base_sp = use_usp ? usp : isp;
    end
endmodule

// File: rtl/irq_ctx_newflag.sv
module irq_ctx_newflag
    import irq_ctx_pkg::*;
(
    input  logic [WORD_W-1:0] old_flg,
    input  irq_class_e        cls,
    input  logic [IPL_W-1:0]  req_lvl,
    input  logic              fixed_en,
    input  logic [IPL_W-1:0]  fixed_lvl,
    output logic [WORD_W-1:0] new_flg
);
    always_comb begin
        new_flg        = old_flg;
        new_flg[I_BIT] = 1'b0;
        new_flg[D_BIT] = 1'b0;
        if (cls != CLS_SW_HI) begin
            new_flg[U_BIT] = 1'b0;
        end
        new_flg[IPL_LSB +: IPL_W] = fixed_en ? fixed_lvl : req_lvl;
    end
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int SP_W = 16,
    parameter int PC_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mem_rdy,
    input  logic [SP_W-1:0]   base_sp,
    input  logic [PC_W-1:0]   pc,
    input  logic [WORD_W-1:0] flg,
    output logic              mem_wr,
    output logic [SP_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              last_ack
);
    localparam logic [SP_W-1:0] STEP = SP_W'(2);

    seq_state_e       state;
    seq_state_e       nxt;
    logic [SP_W-1:0]  sp_work;
    logic [31:0]      pc_ext;

    assign pc_ext   = 32'(pc);
    assign mem_addr = sp_work - STEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Working pointer: loaded at start, stepped down on every accepted write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_work <= '0;
        end else if (start) begin
            sp_work <= base_sp;
        end else if (mem_wr && mem_rdy) begin
            sp_work <= sp_work - STEP;
        end
    end

    always_comb begin
        nxt       = state;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        busy      = 1'b1;
        done      = 1'b0;
        last_ack  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) nxt = ST_PC_HI;
            end
            ST_PC_HI: begin
                mem_wr    = 1'b1;
                mem_wdata = pc_ext[31:16];
                if (mem_rdy) nxt = ST_PC_LO;
            end
            ST_PC_LO: begin
                mem_wr    = 1'b1;
                mem_wdata = pc_ext[15:0];
                if (mem_rdy) nxt = ST_FLAG;
            end
            ST_FLAG: begin
                mem_wr    = 1'b1;
                mem_wdata = flg;
                if (mem_rdy) begin
                    last_ack = 1'b1;
                    nxt      = ST_DONE;
                end
            end
            ST_DONE: begin
                done = 1'b1;
                nxt  = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R2: consecutive pushes step the address down by one word
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_rdy && state != ST_FLAG) |=>
        (mem_wr && mem_addr == $past(mem_addr) - STEP));

    // R8: a stalled write holds its request, address and data
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_rdy) |=>
        (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/irq_ctx_saver.sv
module irq_ctx_saver
    import irq_ctx_pkg::*;
#(
    parameter int PC_W = 20,
    parameter int SP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        irq_class,
    input  logic [2:0]        req_level,
    input  logic              fixed_en,
    input  logic [2:0]        fixed_level,
    input  logic [15:0]       flg_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [SP_W-1:0]   isp_in,
    input  logic [SP_W-1:0]   usp_in,
    input  logic              mem_rdy,
    output logic              mem_wr,
    output logic [SP_W-1:0]   mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       flg_out,
    output logic [SP_W-1:0]   isp_out,
    output logic [SP_W-1:0]   usp_out
);
    irq_class_e          cls_q;
    logic [IPL_W-1:0]    lvl_q;
    logic                fx_en_q;
    logic [IPL_W-1:0]    fx_lvl_q;
    logic [WORD_W-1:0]   flg_q;
    logic [PC_W-1:0]     pc_q;
    logic [SP_W-1:0]     isp_q;
    logic [SP_W-1:0]     usp_q;
    logic                use_usp_q;

    logic                start;
    logic                use_usp;
    logic [SP_W-1:0]     base_sp;
    logic [WORD_W-1:0]   flg_next;
    logic                last_ack;

    assign start = accept && !busy;

    irq_ctx_stacksel #(.SP_W(SP_W)) u_sel (
        .cls     (irq_class_e'(irq_class)),
        .u_flag  (flg_in[U_BIT]),
        .isp     (isp_in),
        .usp     (usp_in),
        .use_usp (use_usp),
        .base_sp (base_sp)
    );

    // Snapshot of the pre-interrupt context, taken only when a sequence starts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q     <= CLS_HW;
            lvl_q     <= '0;
            fx_en_q   <= 1'b0;
            fx_lvl_q  <= '0;
            flg_q     <= '0;
            pc_q      <= '0;
            isp_q     <= '0;
            usp_q     <= '0;
            use_usp_q <= 1'b0;
        end else if (start) begin
            cls_q     <= irq_class_e'(irq_class);
            lvl_q     <= req_level;
            fx_en_q   <= fixed_en;
            fx_lvl_q  <= fixed_level;
            flg_q     <= flg_in;
            pc_q      <= pc_in;
            isp_q     <= isp_in;
            usp_q     <= usp_in;
            use_usp_q <= use_usp;
        end
    end

    irq_ctx_newflag u_flag (
        .old_flg   (flg_q),
        .cls       (cls_q),
        .req_lvl   (lvl_q),
        .fixed_en  (fx_en_q),
        .fixed_lvl (fx_lvl_q),
        .new_flg   (flg_next)
    );

    irq_ctx_seq #(.SP_W(SP_W), .PC_W(PC_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_rdy   (mem_rdy),
        .base_sp   (base_sp),
        .pc        (pc_q),
        .flg       (flg_q),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .last_ack  (last_ack)
    );

    // The last write's address is the final pointer value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_out <= '0;
            isp_out <= '0;
            usp_out <= '0;
        end else if (last_ack) begin
            flg_out <= flg_next;
            if (use_usp_q) begin
                usp_out <= mem_addr;
                isp_out <= isp_q;
            end else begin
                isp_out <= mem_addr;
                usp_out <= usp_q;
            end
        end
    end

    // R6: enable and debug flags are clear in every published flag word
    a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flg_out[I_BIT] && !flg_out[D_BIT]));

    // R3: non high-software classes leave U cleared
    a_r3_u_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls_q != CLS_SW_HI) |-> !flg_out[U_BIT]);

    // R4: high-software class keeps the captured U
    a_r4_u_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls_q == CLS_SW_HI) |-> (flg_out[U_BIT] == flg_q[U_BIT]));

    // R10: snapshot does not move while a sequence runs
    a_r10_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(flg_q) && $stable(pc_q)));
endmodule

// File: tb/irq_ctx_saver_bench.sv
`timescale 1ns/1ps
module irq_ctx_saver_bench;
    localparam int PC_W = 20;
    localparam int SP_W = 16;

    typedef struct packed {
        logic [1:0]  cls;
        logic [2:0]  lvl;
        logic        fx_en;
        logic [2:0]  fx_lvl;
        logic [15:0] flg;
        logic [19:0] pc;
        logic [15:0] isp;
        logic [15:0] usp;
        logic [2:0]  stall;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd5, 1'b0, 3'd0, 16'h00C4, 20'hABCDE, 16'h0400, 16'h0800, 3'd0},
        '{2'd1, 3'd2, 1'b0, 3'd6, 16'h7085, 20'h12345, 16'h1000, 16'h2000, 3'd2},
        '{2'd2, 3'd3, 1'b0, 3'd0, 16'h00C0, 20'hF0001, 16'h0500, 16'h3000, 3'd1},
        '{2'd2, 3'd1, 1'b0, 3'd0, 16'h4044, 20'h5A5A5, 16'h0600, 16'h7000, 3'd0},
        '{2'd0, 3'd2, 1'b1, 3'd7, 16'hFFFF, 20'h00000, 16'h0002, 16'h1234, 3'd3},
        '{2'd3, 3'd4, 1'b0, 3'd0, 16'h0000, 20'hFFFFF, 16'h8000, 16'h9000, 3'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             accept = 1'b0;
    logic [1:0]       irq_class = '0;
    logic [2:0]       req_level = '0;
    logic             fixed_en = 1'b0;
    logic [2:0]       fixed_level = '0;
    logic [15:0]      flg_in = '0;
    logic [PC_W-1:0]  pc_in = '0;
    logic [SP_W-1:0]  isp_in = '0;
    logic [SP_W-1:0]  usp_in = '0;
    logic             mem_rdy = 1'b1;
    logic             mem_wr;
    logic [SP_W-1:0]  mem_addr;
    logic [15:0]      mem_wdata;
    logic             busy;
    logic             done;
    logic [15:0]      flg_out;
    logic [SP_W-1:0]  isp_out;
    logic [SP_W-1:0]  usp_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    irq_ctx_saver #(.PC_W(PC_W), .SP_W(SP_W)) u_irq_ctx_saver (
        .clk(clk), .rst_n(rst_n), .accept(accept), .irq_class(irq_class),
        .req_level(req_level), .fixed_en(fixed_en), .fixed_level(fixed_level),
        .flg_in(flg_in), .pc_in(pc_in), .isp_in(isp_in), .usp_in(usp_in),
        .mem_rdy(mem_rdy), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done), .flg_out(flg_out),
        .isp_out(isp_out), .usp_out(usp_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic uses_usp(input vec_t v);
        return (v.cls == 2'd2) && v.flg[7];
    endfunction

    function automatic logic [15:0] exp_flag(input vec_t v);
        logic [15:0] f;
        f = v.flg;
        f[6] = 1'b0;
        f[2] = 1'b0;
        if (v.cls != 2'd2) f[7] = 1'b0;
        f[14:12] = v.fx_en ? v.fx_lvl : v.lvl;
        return f;
    endfunction

    task automatic drive(input vec_t v);
        irq_class   = v.cls;
        req_level   = v.lvl;
        fixed_en    = v.fx_en;
        fixed_level = v.fx_lvl;
        flg_in      = v.flg;
        pc_in       = v.pc;
        isp_in      = v.isp;
        usp_in      = v.usp;
    endtask

    // Runs one sequence; intrude drives a second accept with other data while busy.
    task automatic run_vec(input vec_t v, input bit intrude);
        logic [15:0] base;
        logic [15:0] data [3];
        logic [15:0] a_prev;
        base    = uses_usp(v) ? v.usp : v.isp;
        data[0] = {12'h000, v.pc[19:16]};
        data[1] = v.pc[15:0];
        data[2] = v.flg;
        @(negedge clk);
        drive(v);
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
        for (int w = 0; w < 3; w++) begin
            mem_rdy = 1'b0;
            for (int s = 0; s < int'(v.stall) + (intrude ? 2 : 0); s++) begin
                if (intrude && w == 0) begin
                    drive('{2'd1, 3'd6, 1'b0, 3'd1, 16'h0F0F, 20'h77777,
                            16'h4444, 16'h5555, 3'd0});
                    accept = 1'b1;
                end
                a_prev = mem_addr;
                @(negedge clk);
                chk(mem_wr === 1'b1 && mem_addr === a_prev, "R8",
                    "stall hold", {15'd0, mem_wr, mem_addr}, {15'd0, 1'b1, a_prev});
            end
            accept  = 1'b0;
            mem_rdy = 1'b1;
            chk(mem_wr === 1'b1 && mem_addr === base - 16'(2 * (w + 1)), "R2",
                "write address", {15'd0, mem_wr, mem_addr},
                {15'd0, 1'b1, base - 16'(2 * (w + 1))});
            chk(mem_wdata === data[w], intrude ? "R5" : "R2", "write data",
                {16'd0, mem_wdata}, {16'd0, data[w]});
            @(negedge clk);
        end
        chk(done === 1'b1 && mem_wr === 1'b0, "R9", "done after last write",
            {30'd0, done, mem_wr}, 32'h2);
        chk(flg_out === exp_flag(v), "R6 R7", "new flag", {16'd0, flg_out},
            {16'd0, exp_flag(v)});
        chk(flg_out[7] === (v.cls == 2'd2 ? v.flg[7] : 1'b0),
            v.cls == 2'd2 ? "R4" : "R3", "U flag", {31'd0, flg_out[7]},
            {31'd0, (v.cls == 2'd2 ? v.flg[7] : 1'b0)});
        chk(isp_out === (uses_usp(v) ? v.isp : v.isp - 16'd6), "R3 R4 R9",
            "isp_out", {16'd0, isp_out},
            {16'd0, (uses_usp(v) ? v.isp : v.isp - 16'd6)});
        chk(usp_out === (uses_usp(v) ? v.usp - 16'd6 : v.usp), "R3 R4 R9",
            "usp_out", {16'd0, usp_out},
            {16'd0, (uses_usp(v) ? v.usp - 16'd6 : v.usp)});
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R9", "done single cycle",
            {30'd0, done, busy}, 32'h0);
        if (intrude) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk(mem_wr === 1'b0 && busy === 1'b0, "R10", "no extra sequence",
                    {30'd0, mem_wr, busy}, 32'h0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_wr === 1'b0 && busy === 1'b0 && done === 1'b0, "R1",
            "control at reset", {29'd0, mem_wr, busy, done}, 32'h0);
        chk(flg_out === 16'h0 && isp_out === 16'h0 && usp_out === 16'h0, "R1",
            "outputs at reset", {flg_out, isp_out ^ usp_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 1'b0);
        end
        // R10 and R5: accept with different data while busy
        run_vec(VECS[2], 1'b1);
        run_vec(VECS[0], 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule